// File: doc/BRIEF.md
# Boot Remap Address Decoder

This block turns a 32-bit bus address into a one-hot slave select for a microcontroller memory map. The map has four external static regions, one SDRAM region and an internal region that holds a small boot ROM, the peripheral space and a window that leads to a secondary bus serving a frame buffer. An address that lands nowhere raises a decode-error flag instead of a select.

A boot-strap pin decides whether the 1 KB ROM also appears at address zero. The block loads a remap bit from the inverted pin on every clock while reset is held. The value it holds when reset drops is the boot choice. Software can later overwrite this bit through a one-bit register port, which removes or restores the alias. Select outputs are registered, so each select reflects the address and the remap bit sampled at the previous rising clock edge.

Top module: `boot_remap_decoder`

## Requirements
- R1: On the first cycle after reset is released, `reg_rdata` equals the inverse of `boot_pin` as sampled on the last clock edge with reset high. A low pin gives 1 (alias on). A high pin gives 0.
- R2: When `reg_we` is 1 on a rising edge outside reset, `reg_rdata` takes the value of `reg_wdata` after that edge. With `reg_we` at 0 the bit is kept.
- R3: With the remap bit at 1, addresses 0x0000_0000 to 0x0000_03FF select the ROM, which is `sel_o` bit 0.
- R4: Address 0x0000_0400 up to 0x0FFF_FFFF always selects static chip select 0, which is `sel_o` bit 1. Addresses 0x0000_0000 to 0x0000_03FF also select bit 1 when the remap bit is 0.
- R5: The ROM window 0xF900_0000 to 0xF9FF_FFFF selects `sel_o` bit 0 whatever the remap bit is.
- R6: The regions 0x1xxx_xxxx, 0x2xxx_xxxx and 0x3xxx_xxxx select static chip selects 1, 2 and 3 on `sel_o` bits 2, 3 and 4. Region 0x4xxx_xxxx selects SDRAM on bit 5.
- R7: 0xFF00_0000 to 0xFFFF_FFFF selects the peripheral space on `sel_o` bit 6. 0xFC00_0000 to 0xFCFF_FFFF selects the secondary bus on bit 7.
- R8: Any other address (regions 0x5 to 0xE, and 0xF0, 0xF1 … 0xF8, 0xFA, 0xFB, 0xFD, 0xFE in the top byte) drives `err_o` to 1 and all of `sel_o` to 0.
- R9: While reset is high, `sel_o` and `err_o` are 0. Outside reset, they show the decode of the address and remap bit present at the previous rising edge.
- R10: Outside reset, exactly one of the nine bits {`err_o`, `sel_o`} is 1 in each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_pin | input | 1 | Boot-strap pin. Low means the ROM is aliased at zero |
| reg_we | input | 1 | Write strobe for the remap bit |
| reg_wdata | input | 1 | New remap bit value |
| reg_rdata | output | 1 | Current remap bit |
| addr_i | input | 32 | Bus address to decode |
| sel_o | output | 8 | One-hot slave select, registered |
| err_o | output | 1 | Decode error, registered |

## Verification
Addresses are placed on both sides of each boundary that the decode depends on: 0x3FF and 0x400 at the bottom of region zero, the first and last byte of every 256 MB region, and the edges of each 16 MB window in the internal region. Each of these is run with the remap bit at 1 and at 0. This separates an alias that is too wide or too narrow from one that ignores the remap bit, and it separates the ROM window from its reserved neighbours. Two resets, one with the pin low and one with it high, show that the pin, rather than a fixed constant, sets the boot state. Software writes in both directions show that a write can remove the alias and restore it.

// File: rtl/brd_pkg.sv
package brd_pkg;
  localparam int NUM_CS     = 4;
  localparam int SEL_ROM    = 0;
  localparam int SEL_CS0    = 1;
  localparam int SEL_SDRAM  = SEL_CS0 + NUM_CS;
  localparam int SEL_PERIPH = SEL_SDRAM + 1;
  localparam int SEL_FBUF   = SEL_PERIPH + 1;
  localparam int NSEL       = SEL_FBUF + 1;

  // region and window codes, top nibble and next nibble of the address
  localparam int SDRAM_REGION = 4;
  localparam int INT_REGION   = 15;
  localparam int ROM_WIN      = 9;
  localparam int FBUF_WIN     = 12;
  localparam int PERIPH_WIN   = 15;
endpackage

// File: rtl/brd_remap_reg.sv
module brd_remap_reg (
  input  logic clk,
  input  logic rst,
  input  logic boot_pin,
  input  logic we,
  input  logic wdata,
  output logic remap_q
);
  always_ff @(posedge clk) begin
    if (rst)     remap_q <= ~boot_pin;
    else if (we) remap_q <= wdata;
  end
endmodule

// File: rtl/brd_region_decode.sv
module brd_region_decode
  import brd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int REGION_W = 4,
  parameter int WIN_W    = 4,
  parameter int ROM_AW   = 10
) (
  input  logic [ADDR_W-1:ROM_AW] addr_hi,
  input  logic                   remap,
  output logic [NSEL-1:0]        sel,
  output logic                   err
);
  localparam int HI_W = ADDR_W - ROM_AW;

  logic [REGION_W-1:0] region;
  logic [WIN_W-1:0]    win;
  logic                alias_hit;
  logic [NUM_CS-1:0]   cs_hit;

  assign region    = addr_hi[ADDR_W-1 -: REGION_W];
  assign win       = addr_hi[ADDR_W-REGION_W-1 -: WIN_W];
  assign alias_hit = remap && (addr_hi == {HI_W{1'b0}});

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    if (i == 0) begin : g_first
      assign cs_hit[i] = (region == REGION_W'(i)) && !alias_hit;
    end else begin : g_rest
      assign cs_hit[i] = (region == REGION_W'(i));
    end
  end

  always_comb begin
    sel = '0;
    err = 1'b0;
    if (alias_hit) begin
      sel[SEL_ROM] = 1'b1;
    end else if (|cs_hit) begin
      sel[SEL_CS0 +: NUM_CS] = cs_hit;
    end else if (region == REGION_W'(SDRAM_REGION)) begin
      sel[SEL_SDRAM] = 1'b1;
    end else if (region == REGION_W'(INT_REGION)) begin
      if (win == WIN_W'(ROM_WIN))         sel[SEL_ROM]    = 1'b1;
      else if (win == WIN_W'(FBUF_WIN))   sel[SEL_FBUF]   = 1'b1;
      else if (win == WIN_W'(PERIPH_WIN)) sel[SEL_PERIPH] = 1'b1;
      else                                err             = 1'b1;
    end else begin
      err = 1'b1;
    end
  end
endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
  import brd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int REGION_W = 4,
  parameter int WIN_W    = 4,
  parameter int ROM_AW   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_pin,
  input  logic              reg_we,
  input  logic              reg_wdata,
  output logic              reg_rdata,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NSEL-1:0]   sel_o,
  output logic              err_o
);
  logic            remap_q;
  logic [NSEL-1:0] sel_d;
  logic            err_d;
  logic            unused_low;

  assign unused_low = ^addr_i[ROM_AW-1:0];

  brd_remap_reg u_remap (
    .clk(clk), .rst(rst), .boot_pin(boot_pin),
    .we(reg_we), .wdata(reg_wdata), .remap_q(remap_q)
  );

  brd_region_decode #(
    .ADDR_W(ADDR_W), .REGION_W(REGION_W), .WIN_W(WIN_W), .ROM_AW(ROM_AW)
  ) u_dec (
    .addr_hi(addr_i[ADDR_W-1:ROM_AW]), .remap(remap_q),
    .sel(sel_d), .err(err_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o <= '0;
      err_o <= 1'b0;
    end else begin
      sel_o <= sel_d;
      err_o <= err_d;
    end
  end

  assign reg_rdata = remap_q;
endmodule

// File: rtl/brd_chk.sv
module brd_chk
  import brd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ROM_AW = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              boot_pin,
  input logic              reg_we,
  input logic              reg_wdata,
  input logic              reg_rdata,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NSEL-1:0]   sel_o,
  input logic              err_o
);
  localparam int RS = ADDR_W - 4;

  // R1
  boot_load_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> reg_rdata == !$past(boot_pin));

  // R2
  sw_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(reg_we)) |-> reg_rdata == $past(reg_wdata));

  // R3
  rom_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(reg_rdata) && ($past(addr_i) >> ROM_AW) == 0)
      |-> sel_o[SEL_ROM]);

  // R6
  sdram_region_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(addr_i[ADDR_W-1:RS]) == 4'd4) |-> sel_o[SEL_SDRAM]);

  // R8
  reserved_err_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(addr_i[ADDR_W-1:RS]) > 4'd4
     && $past(addr_i[ADDR_W-1:RS]) < 4'd15) |-> (err_o && sel_o == '0));

  // R10
  one_hot_out_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $countones({err_o, sel_o}) == 1);
endmodule

bind boot_remap_decoder brd_chk #(.ADDR_W(ADDR_W), .ROM_AW(ROM_AW)) u_chk (
  .clk(clk), .rst(rst), .boot_pin(boot_pin), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .addr_i(addr_i),
  .sel_o(sel_o), .err_o(err_o)
);

// File: tb/boot_remap_decoder_tb.sv
module boot_remap_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        boot_pin = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_wdata = 1'b0;
  logic        reg_rdata;
  logic [31:0] addr_i = '0;
  logic [7:0]  sel_o;
  logic        err_o;

  int total = 0;
  int bad = 0;

  boot_remap_decoder u_dut (
    .clk(clk), .rst(rst), .boot_pin(boot_pin), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .addr_i(addr_i),
    .sel_o(sel_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // expected select word: bit 8 is err, bits 7:0 are sel
  task automatic probe(string req, logic [31:0] a, logic [8:0] exp);
    @(negedge clk);
    addr_i = a;
    @(posedge clk);
    #1;
    check(req, {23'd0, err_o, sel_o}, {23'd0, exp});
  endtask

  task automatic do_reset(logic pin);
    @(negedge clk);
    rst = 1'b1;
    boot_pin = pin;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset sel", {23'd0, err_o, sel_o}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R1 boot load", {31'd0, reg_rdata}, {31'd0, ~pin});
  endtask

  task automatic sw_write(logic v);
    @(negedge clk);
    reg_we = 1'b1;
    reg_wdata = v;
    @(posedge clk);
    #1;
    reg_we = 1'b0;
    check("R2 write", {31'd0, reg_rdata}, {31'd0, v});
  endtask

  task automatic t_alias_on;
    probe("R3 alias low", 32'h0000_0000, 9'h001);
    probe("R3 alias top", 32'h0000_03FF, 9'h001);
    probe("R4 past alias", 32'h0000_0400, 9'h002);
    probe("R4 cs0 end", 32'h0FFF_FFFF, 9'h002);
  endtask

  task automatic t_alias_off;
    probe("R4 cs0 at zero", 32'h0000_0000, 9'h002);
    probe("R4 cs0 3ff", 32'h0000_03FF, 9'h002);
  endtask

  task automatic t_external;
    probe("R6 cs1", 32'h1000_0000, 9'h004);
    probe("R6 cs2", 32'h2ABC_0000, 9'h008);
    probe("R6 cs3", 32'h3FFF_FFFF, 9'h010);
    probe("R6 sdram lo", 32'h4000_0000, 9'h020);
    probe("R6 sdram hi", 32'h4FFF_FFFF, 9'h020);
  endtask

  task automatic t_internal;
    probe("R5 rom win", 32'hF900_0000, 9'h001);
    probe("R5 rom win end", 32'hF9FF_FFFF, 9'h001);
    probe("R7 periph", 32'hFF00_0000, 9'h040);
    probe("R7 periph end", 32'hFFFF_FFFC, 9'h040);
    probe("R7 fbuf", 32'hFC00_0000, 9'h080);
    probe("R7 fbuf end", 32'hFCFF_FFFF, 9'h080);
  endtask

  task automatic t_reserved;
    probe("R8 region5", 32'h5000_0000, 9'h100);
    probe("R8 regionE", 32'hEFFF_FFFF, 9'h100);
    probe("R8 F0", 32'hF000_0000, 9'h100);
    probe("R8 F8", 32'hF8FF_FFFF, 9'h100);
    probe("R8 FA", 32'hFA00_0000, 9'h100);
    probe("R8 FB", 32'hFBFF_FFFF, 9'h100);
    probe("R8 FD", 32'hFD00_0000, 9'h100);
    probe("R8 FE", 32'hFEFF_FFFF, 9'h100);
  endtask

  task automatic t_latency;
    // R9: output follows the address of the previous edge only
    @(negedge clk);
    addr_i = 32'h1000_0000;
    @(posedge clk);
    @(negedge clk);
    addr_i = 32'h5000_0000;
    #1;
    check("R9 held before edge", {23'd0, err_o, sel_o}, 32'h004);
    @(posedge clk);
    #1;
    check("R9 after edge", {23'd0, err_o, sel_o}, 32'h100);
  endtask

  initial begin
    fork
      begin
        do_reset(1'b0);
        t_alias_on();
        t_internal();
        t_external();
        t_reserved();
        t_latency();
        // R2: keep bit when reg_we is low
        @(negedge clk);
        reg_wdata = 1'b0;
        @(posedge clk);
        #1;
        check("R2 no write keeps", {31'd0, reg_rdata}, 32'd1);
        sw_write(1'b0);
        t_alias_off();
        probe("R5 rom win no alias", 32'hF900_0200, 9'h001);
        sw_write(1'b1);
        probe("R3 restored", 32'h0000_0100, 9'h001);
        do_reset(1'b1);
        t_alias_off();
        probe("R5 rom win pin high", 32'hF900_0000, 9'h001);
      end
      begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule